// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse Width Modulator

This block produces four independent pulse-width-modulated outputs from one input clock. A host programs it through a small word-addressed register interface. One control word holds a run-enable bit and a two-bit clock-divider select for every channel. Each channel also has its own configuration word, which packs a 16-bit period length (the timebase) and a 16-bit high time (the duty). Both are counted in prescaled ticks. The host works out the divider and the tick counts from the wanted frequency and duty cycle, and the block only carries them out.

Every channel contains a small state machine with two states. `CH_IDLE` holds the counters in reset and the output low. `CH_RUN` steps a tick prescaler and a period counter. The transitions are:

- **START** (`CH_IDLE` to `CH_RUN`): taken when the channel's enable bit is set. It copies the programmed timebase, duty and divider into active registers.
- **STOP** (`CH_RUN` to `CH_IDLE`): taken when the enable bit is cleared.
- **WRAP** (`CH_RUN` to `CH_RUN`): taken at the last tick of a period. It restarts the counter and copies a fresh set of active values.

Because new settings only take effect at a period boundary, a channel that is running never emits a shortened or stretched pulse.

Top module: `pwm_bank`

## Requirements
- R1: After reset every mapped register reads 0 and all four outputs are low.
- R2: The control word sits at byte address 0x00 and its fields are laid out as follows.
  - Bit n enables channel n.
  - Bits [5+2n:4+2n] hold channel n's divider select.
  - Bits 31:12 read as 0.

  Channel n's configuration word sits at 0x04+4n, with the timebase in bits 15:0 and the duty in bits 31:16. A mapped register reads back the value last written to it. A write to any other address changes no register, and reading such an address returns 0.
- R3: The divider select codes are 0, 1, 2 and 3. They make one tick last 1, 8, 64 and 512 clock cycles respectively.
- R4: A running channel with 0 < duty < timebase repeats a period of timebase×div cycles. Each period is high for duty×div cycles and then low for the rest.
- R5: A timebase value of 0 stands for a period of 65536 ticks.
- R6: When duty ≥ timebase (timebase nonzero), the output stays high. When duty is 0, the output stays low.
- R7: A change to timebase, duty or divider made while a channel runs does not alter the current period. It takes effect from the next period.
- R8: Clearing a channel's enable bit drives its output low in the cycle after the write. Setting the bit again starts a fresh period, whose output goes high one cycle after the write takes effect when duty is nonzero.
- R9: The channels run independently: each output depends only on its own enable, divider, timebase and duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers and counters |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, sampled on the rising clock edge |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte address of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| pwm_out | output | 4 | One modulated output per channel |

## Verification
The bench builds the block with its default parameters: four channels, 16-bit counters and a divider step of 8 per stage. This lets the bench reach the divide-by-512 setting with a short timebase, and a full 65536-tick period at divider 1, within the cycle budget. High and low run lengths are measured at the output pins for random timebase, duty, divider and channel choices. Directed cases cover the all-high and all-low duty settings, a duty change in the middle of a period, the stop and restart latency, and two channels with different periods running side by side.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    // Per-channel run state
    typedef enum logic [0:0] {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

    // Width of one divider select field
    localparam int SEL_W = 2;

    // First control-word bit used by the divider select fields
    localparam int CTRL_SEL_BASE = 4;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int STEP_LOG2 = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int PRE_W = 3 * STEP_LOG2;

    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] limit;

    // Terminal count for each divider setting: 0, 2^s-1, 2^2s-1, 2^3s-1
    always_comb begin
        unique case (sel)
            2'd0:    limit = '0;
            2'd1:    limit = PRE_W'((1 << STEP_LOG2) - 1);
            2'd2:    limit = PRE_W'((1 << (2 * STEP_LOG2)) - 1);
            default: limit = '1;
        endcase
    end

    assign tick = (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_regfile.sv
module pwm_regfile
    import pwm_bank_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [2*CNT_W-1:0]           wr_data,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [2*CNT_W-1:0]           rd_data,
    output logic [NCH-1:0]               ch_en,
    output logic [NCH-1:0][SEL_W-1:0]    ch_sel,
    output logic [NCH-1:0][CNT_W-1:0]    ch_tb,
    output logic [NCH-1:0][CNT_W-1:0]    ch_duty
);
    localparam int DATA_W = 2 * CNT_W;
    localparam int CTRL_W = CTRL_SEL_BASE + SEL_W * NCH;

    logic [CTRL_W-1:0]            ctrl_q;
    logic [NCH-1:0][DATA_W-1:0]   cfg_q;

    // Register writes; unmatched addresses fall through untouched
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cfg_q  <= '0;
        end else if (wr_en) begin
            if (wr_addr == '0) begin
                ctrl_q <= wr_data[CTRL_W-1:0];
            end
            for (int n = 0; n < NCH; n++) begin
                if (wr_addr == ADDR_W'(4 + 4 * n)) begin
                    cfg_q[n] <= wr_data;
                end
            end
        end
    end

    // Combinational read mux
    always_comb begin
        rd_data = '0;
        if (rd_addr == '0) begin
            rd_data[CTRL_W-1:0] = ctrl_q;
        end
        for (int n = 0; n < NCH; n++) begin
            if (rd_addr == ADDR_W'(4 + 4 * n)) begin
                rd_data = cfg_q[n];
            end
        end
    end

    // Field extraction per channel
    always_comb begin
        ch_en = ctrl_q[NCH-1:0];
        for (int n = 0; n < NCH; n++) begin
            ch_sel[n]  = ctrl_q[CTRL_SEL_BASE + SEL_W * n +: SEL_W];
            ch_tb[n]   = cfg_q[n][CNT_W-1:0];
            ch_duty[n] = cfg_q[n][DATA_W-1:CNT_W];
        end
    end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_bank_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int STEP_LOG2 = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel_in,
    input  logic [CNT_W-1:0] tb_in,
    input  logic [CNT_W-1:0] duty_in,
    output logic             pwm_o,
    output logic             run_o,
    output logic             wrap_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] tb_o,
    output logic [CNT_W-1:0] duty_o
);
    ch_state_e        state_q, state_d;
    logic [SEL_W-1:0] act_sel;
    logic [CNT_W-1:0] act_tb;
    logic [CNT_W-1:0] act_duty;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;
    logic             last;

    pwm_prescaler #(.STEP_LOG2(STEP_LOG2)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != CH_RUN),
        .sel   (act_sel),
        .tick  (tick)
    );

    // A timebase of 0 wraps to all ones, giving a full 2^CNT_W period
    assign last = (cnt_q == act_tb - CNT_W'(1));

    // Next-state logic: START, STOP, and WRAP (stays in CH_RUN)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (en)  state_d = CH_RUN;
            CH_RUN:  if (!en) state_d = CH_IDLE;
            default:          state_d = CH_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Counter and active-settings registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            act_sel  <= '0;
            act_tb   <= '0;
            act_duty <= '0;
        end else if (state_q == CH_IDLE) begin
            cnt_q <= '0;
            if (en) begin
                act_sel  <= sel_in;
                act_tb   <= tb_in;
                act_duty <= duty_in;
            end
        end else if (!en) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (last) begin
                cnt_q    <= '0;
                act_sel  <= sel_in;
                act_tb   <= tb_in;
                act_duty <= duty_in;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        run_o  = (state_q == CH_RUN);
        pwm_o  = run_o && en && (cnt_q < act_duty);
        wrap_o = run_o && tick && last;
        cnt_o  = cnt_q;
        tb_o   = act_tb;
        duty_o = act_duty;
    end

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NCH       = 4,
    parameter int CNT_W     = 16,
    parameter int STEP_LOG2 = 3,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [2*CNT_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [2*CNT_W-1:0]   rd_data,
    output logic [NCH-1:0]       pwm_out
);
    logic [NCH-1:0]              ch_en;
    logic [NCH-1:0][SEL_W-1:0]   ch_sel;
    logic [NCH-1:0][CNT_W-1:0]   ch_tb;
    logic [NCH-1:0][CNT_W-1:0]   ch_duty;
    logic [NCH-1:0]              run_vec;
    logic [NCH-1:0]              wrap_vec;
    logic [NCH-1:0][CNT_W-1:0]   cnt_arr;
    logic [NCH-1:0][CNT_W-1:0]   act_tb_arr;
    logic [NCH-1:0][CNT_W-1:0]   act_duty_arr;

    pwm_regfile #(
        .NCH    (NCH),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .ch_en   (ch_en),
        .ch_sel  (ch_sel),
        .ch_tb   (ch_tb),
        .ch_duty (ch_duty)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm_channel #(
            .CNT_W     (CNT_W),
            .STEP_LOG2 (STEP_LOG2)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (ch_en[g]),
            .sel_in  (ch_sel[g]),
            .tb_in   (ch_tb[g]),
            .duty_in (ch_duty[g]),
            .pwm_o   (pwm_out[g]),
            .run_o   (run_vec[g]),
            .wrap_o  (wrap_vec[g]),
            .cnt_o   (cnt_arr[g]),
            .tb_o    (act_tb_arr[g]),
            .duty_o  (act_duty_arr[g])
        );
    end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
    parameter int NCH    = 4,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic [ADDR_W-1:0]          wr_addr,
    input logic [NCH-1:0]             ch_en,
    input logic [NCH-1:0]             pwm_out,
    input logic [NCH-1:0]             run_vec,
    input logic [NCH-1:0]             wrap_vec,
    input logic [NCH-1:0][CNT_W-1:0]  cnt_arr,
    input logic [NCH-1:0][CNT_W-1:0]  act_tb_arr,
    input logic [NCH-1:0][CNT_W-1:0]  act_duty_arr
);
    logic wr_unmapped;
    assign wr_unmapped = wr_en &&
        ((wr_addr[1:0] != 2'b00) || (wr_addr > ADDR_W'(4 * NCH)));

    AST_UNMAPPED_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_unmapped |=> $stable(ch_en)); // R2

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_en[g] |-> !pwm_out[g]); // R8

        AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            (run_vec[g] && !ch_en[g]) |=> !run_vec[g]); // R8

        AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(run_vec[g]) && ch_en[g] && act_duty_arr[g] != '0) |-> pwm_out[g]); // R8

        AST_CNT_BELOW_TB: assert property (@(posedge clk) disable iff (!rst_n)
            (run_vec[g] && act_tb_arr[g] != '0) |-> (cnt_arr[g] < act_tb_arr[g])); // R4

        AST_CFG_HELD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
            (run_vec[g] && ch_en[g] && !wrap_vec[g]) |=>
                ($stable(act_tb_arr[g]) && $stable(act_duty_arr[g]))); // R7

        AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (act_duty_arr[g] == '0) |-> !pwm_out[g]); // R6

        AST_FULL_DUTY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            (run_vec[g] && ch_en[g] && act_tb_arr[g] != '0 &&
             act_duty_arr[g] >= act_tb_arr[g]) |-> pwm_out[g]); // R6
    end

endmodule

bind pwm_bank pwm_bank_chk #(
    .NCH    (NCH),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .ch_en        (ch_en),
    .pwm_out      (pwm_out),
    .run_vec      (run_vec),
    .wrap_vec     (wrap_vec),
    .cnt_arr      (cnt_arr),
    .act_tb_arr   (act_tb_arr),
    .act_duty_arr (act_duty_arr)
);

// File: tb/tb_pwm_bank.sv
`timescale 1ns/1ps
module tb_pwm_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [3:0]  pwm_out;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pwm_bank dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .pwm_out (pwm_out)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 180000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=180000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    function automatic int div_of(input int sel);
        return 1 << (3 * sel);
    endfunction

    function automatic int tb_eff(input int tb);
        return (tb == 0) ? 65536 : tb;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        rd_addr = a;
        #0.5;
        check(rd_data == exp, req, rd_data, exp);
    endtask

    task automatic measure(input int ch, output int hi, output int lo);
        int g = 0;
        hi = 0; lo = 0;
        while (!pwm_out[ch] && g < 70000) begin @(negedge clk); g++; end
        while (pwm_out[ch])  begin hi++; @(negedge clk); end
        while (!pwm_out[ch]) begin lo++; @(negedge clk); end
    endtask

    task automatic start_ch(input int ch, input int tb, input int duty, input int sel);
        bus_wr(8'h00, 32'h0);
        bus_wr(8'(4 + 4 * ch), {duty[15:0], tb[15:0]});
        bus_wr(8'h00, (32'h1 << ch) | (32'(sel) << (4 + 2 * ch)));
    endtask

    task automatic wave_case(input int ch, input int tb, input int duty, input int sel, input string req);
        int hi, lo, d;
        d = div_of(sel);
        start_ch(ch, tb, duty, sel);
        measure(ch, hi, lo);
        check(hi == duty * d, {req, " high"}, hi, duty * d);
        check(lo == (tb_eff(tb) - duty) * d, {req, " low"}, lo, (tb_eff(tb) - duty) * d);
    endtask

    task automatic const_case(input int ch, input int tb, input int duty, input int sel,
                              input bit lvl, input string req);
        int bad = 0;
        start_ch(ch, tb, duty, sel);
        @(negedge clk);
        repeat (3 * tb * div_of(sel)) begin
            if (pwm_out[ch] !== lvl) bad++;
            @(negedge clk);
        end
        check(bad == 0, req, bad, 0);
    endtask

    initial begin
        int seed_ok;
        seed_ok = $urandom(32'd20240611);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a <= 16; a += 4) read_chk(8'(a), 32'h0, "R1 reg");
        check(pwm_out == 4'h0, "R1 outputs", pwm_out, 0);

        // R2: readback and unmapped writes
        begin
            logic [31:0] cv [4];
            logic [31:0] ctl;
            for (int n = 0; n < 4; n++) begin
                cv[n] = $urandom;
                bus_wr(8'(4 + 4 * n), cv[n]);
            end
            ctl = $urandom & 32'hFFFF_FFF0;
            bus_wr(8'h00, ctl);
            read_chk(8'h00, ctl & 32'h0000_0FFF, "R2 ctrl readback");
            bus_wr(8'h14, 32'hFFFF_FFFF);
            bus_wr(8'h02, 32'hFFFF_FFFF);
            bus_wr(8'h41, 32'hFFFF_FFFF);
            read_chk(8'h00, ctl & 32'h0000_0FFF, "R2 ctrl after unmapped");
            for (int n = 0; n < 4; n++) read_chk(8'(4 + 4 * n), cv[n], "R2 cfg readback");
            read_chk(8'h14, 32'h0, "R2 unmapped read");
            check(pwm_out == 4'h0, "R2 outputs after unmapped", pwm_out, 0);
        end

        // R3 / R4: random waveforms across channels and dividers
        for (int i = 0; i < 6; i++) begin
            int ch, sel, tb, duty;
            ch   = int'($urandom % 4);
            sel  = int'($urandom % 3);
            tb   = 2 + int'($urandom % 29);
            duty = 1 + int'($urandom % (tb - 1));
            wave_case(ch, tb, duty, sel, "R4 R3 random");
        end
        // R3: divide by 512
        wave_case(3, 3, 1, 3, "R3 div512");

        // R5: timebase 0 means 65536 ticks
        wave_case(0, 0, 1, 0, "R5 tb zero");

        // R6: saturated and empty duty
        const_case(1, 5, 9, 1, 1'b1, "R6 duty>=tb high");
        const_case(2, 5, 0, 0, 1'b0, "R6 duty zero low");

        // R7: duty change mid-period applies at next period
        begin
            int h1 = 0, hi, lo;
            start_ch(1, 10, 5, 0);
            fork
                begin
                    repeat (10) begin @(negedge clk); if (pwm_out[1]) h1++; end
                end
                begin
                    repeat (2) @(negedge clk);
                    bus_wr(8'h08, {16'd8, 16'd10});
                end
            join
            check(h1 == 5, "R7 current period kept", h1, 5);
            measure(1, hi, lo);
            check(hi == 8, "R7 next period high", hi, 8);
            check(lo == 2, "R7 next period low", lo, 2);
        end

        // R8: stop and restart
        begin
            int hi, lo;
            start_ch(2, 8, 4, 0);
            @(negedge clk);
            bus_wr(8'h00, 32'h0);
            check(pwm_out[2] == 1'b0, "R8 low after stop", pwm_out[2], 0);
            repeat (3) @(negedge clk);
            bus_wr(8'h00, 32'h4);
            check(pwm_out[2] == 1'b0, "R8 start latency", pwm_out[2], 0);
            @(negedge clk);
            check(pwm_out[2] == 1'b1, "R8 high on restart", pwm_out[2], 1);
            measure(2, hi, lo);
            check(hi == 4 && lo == 4, "R8 fresh period", hi * 100 + lo, 404);
        end

        // R9: two channels side by side, others off
        begin
            int h [4];
            for (int n = 0; n < 4; n++) h[n] = 0;
            bus_wr(8'h00, 32'h0);
            bus_wr(8'h04, {16'd1, 16'd4});
            bus_wr(8'h08, {16'd3, 16'd6});
            bus_wr(8'h00, 32'h3 | (32'h1 << 6));
            repeat (192) begin
                @(negedge clk);
                for (int n = 0; n < 4; n++) if (pwm_out[n]) h[n]++;
            end
            check(h[0] == 48, "R9 ch0 high count", h[0], 48);
            check(h[1] == 96, "R9 ch1 high count", h[1], 96);
            check(h[2] == 0 && h[3] == 0, "R9 idle channels", h[2] + h[3], 0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule